// File: doc/BRIEF.md
# Collision-Vector Pipeline Initiation Controller

This block sits at the entry of a nonlinear pipeline whose stages may be revisited through feedforward and feedback paths. It decides in every clock cycle whether a new task may be started without any two tasks ever occupying the same stage in the same cycle. The stage usage of one task is fixed at elaboration by a reservation table parameter. Each row is a stage and each column is a clock cycle counted from the start of the task, so the number of columns is the evaluation time of the function.

From the table the block derives, at elaboration, the set of forbidden latencies as a collision vector. A latency is the distance in cycles between two successive initiations. At run time a shifting state register, seeded from that vector on every grant, answers each request in the same cycle. Two counters give the number of granted initiations and the span in cycles from the first to the most recent grant. Their ratio gives the average latency the schedule achieved.

Top module: `cvp_init_ctrl`

## Requirements
- R1: `coll_vec_o` is `NUM_COLS-1` bits wide. Bit `i-1` is 1 exactly when some stage row of `RES_TABLE` has marks in two columns whose distance is `i`; otherwise latency `i` is permissible and the bit is 0. Stage `s`, column `c` of the table is bit `s*NUM_COLS+c`.
- R2: After reset `state_o`, `grant_cnt_o` and `span_cnt_o` are zero, so the first request after reset is always granted.
- R3: In any cycle, `grant_o` is 1 exactly when `req_i` is 1 and starting a task in that cycle would not put it on a stage that an earlier granted task uses in the same cycle.
- R4: Bit 0 of `state_o` marks the current cycle as forbidden, and bit `j` marks the cycle `j` ahead. Each cycle the state shifts one place toward bit 0. On a grant the shifted value is ORed with the collision vector.
- R5: A cycle with `req_i` low gives no grant and only shifts the state.
- R6: With a diagonal table (one mark per stage, at the stage's own column) the collision vector is all zero and every request is granted.
- R7: `grant_cnt_o` increases by one in the cycle after each grant and saturates at all ones.
- R8: `span_cnt_o` holds the number of cycles from the first granted initiation to the most recent one, and never decreases.
- R9: Under any request pattern, no stage is claimed by two granted tasks in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | A task asks to enter the pipeline this cycle |
| grant_o | output | 1 | The task may enter this cycle (combinational from `req_i`) |
| state_o | output | NUM_COLS-1 | Current forbidden-latency state, bit 0 = this cycle |
| coll_vec_o | output | NUM_COLS-1 | Collision vector derived from the table |
| grant_cnt_o | output | CNT_W | Granted initiations since reset |
| span_cnt_o | output | CNT_W | Cycles from the first to the latest grant |

## Verification
The bench builds two instances. The first uses three stages over six cycles, with marks placed so that latencies 2 and 5 are forbidden. With a continuous request stream this gives a repeating greedy pattern of latencies 1, 3, 3, which exercises both blocked cycles and merged state bits. The second uses a 4×4 diagonal table, which shows the linear case, where every request must pass. Both see the same idle, dense and pseudo-random request streams. An occupancy model written straight from the table supplies the expected grants and counter values, and a scoreboard checks that no stage is claimed twice.

// File: rtl/cvp_pkg.sv
package cvp_pkg;

    // Smallest table the controller accepts: one column gives no latency to check.
    localparam int unsigned CVP_MIN_COLS = 2;

    // Saturating increment on a counter held in the low `width` bits.
    function automatic logic [63:0] sat_step(input logic [63:0] cur,
                                             input int unsigned width,
                                             input logic en);
        logic [63:0] lim;
        lim = (width >= 64) ? {64{1'b1}} : ((64'd1 << width) - 64'd1);
        if (en && (cur != lim)) begin
            return cur + 64'd1;
        end
        return cur;
    endfunction

endpackage

// File: rtl/cvp_forbid_calc.sv
module cvp_forbid_calc #(
    parameter int unsigned NUM_STAGES = 3,
    parameter int unsigned NUM_COLS   = 6,
    parameter logic [NUM_STAGES*NUM_COLS-1:0] RES_TABLE = '0,
    localparam int unsigned CV_W = NUM_COLS - 1
) (
    output logic [CV_W-1:0] coll_vec_o
);

    // One bit per candidate latency: set when any row repeats at that distance.
    for (genvar lat = 1; lat < NUM_COLS; lat++) begin : g_lat
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int s = 0; s < NUM_STAGES; s++) begin
                for (int c = 0; c + lat < NUM_COLS; c++) begin
                    hit = hit | (RES_TABLE[s*NUM_COLS + c] & RES_TABLE[s*NUM_COLS + c + lat]);
                end
            end
        end
        assign coll_vec_o[lat-1] = hit;
    end

endmodule

// File: rtl/cvp_state.sv
module cvp_state #(
    parameter int unsigned CV_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_i,
    input  logic [CV_W-1:0] coll_vec_i,
    output logic            grant_o,
    output logic [CV_W-1:0] state_o
);

    typedef struct packed {
        logic [CV_W-1:0] vec;
    } st_t;

    st_t  st_d, st_q;
    logic grant;

    always_comb begin
        // Bit 0 of the state covers the present cycle.
        grant    = rst_n & req_i & ~st_q.vec[0];
        st_d.vec = st_q.vec >> 1;
        if (grant) begin
            st_d.vec = st_d.vec | coll_vec_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o = grant;
    assign state_o = st_q.vec;

    assert_shift_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(grant_o)) |-> (st_q.vec == ($past(st_q.vec) >> 1)));

    assert_merge_on_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(grant_o)) |-> (st_q.vec == (($past(st_q.vec) >> 1) | coll_vec_i)));

    assert_lat1_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(grant_o) && coll_vec_i[0]) |-> !grant_o);

endmodule

// File: rtl/cvp_perf_cnt.sv
module cvp_perf_cnt #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant_i,
    output logic [CNT_W-1:0] grant_cnt_o,
    output logic [CNT_W-1:0] span_cnt_o
);

    import cvp_pkg::*;

    typedef struct packed {
        logic             started;
        logic [CNT_W-1:0] elapsed;
        logic [CNT_W-1:0] gcnt;
        logic [CNT_W-1:0] span;
    } pc_t;

    pc_t pc_d, pc_q;

    always_comb begin
        pc_d         = pc_q;
        pc_d.started = pc_q.started | grant_i;
        // elapsed equals cycles since the first grant, zero in that grant's cycle
        pc_d.elapsed = CNT_W'(sat_step(64'(pc_q.elapsed), CNT_W, pc_q.started | grant_i));
        pc_d.gcnt    = CNT_W'(sat_step(64'(pc_q.gcnt), CNT_W, grant_i));
        if (grant_i) begin
            pc_d.span = pc_q.elapsed;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign grant_cnt_o = pc_q.gcnt;
    assign span_cnt_o  = pc_q.span;

    assert_grant_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(grant_i) && ($past(grant_cnt_o) != {CNT_W{1'b1}}))
        |-> (grant_cnt_o == $past(grant_cnt_o) + 1'b1));

    assert_span_monotone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (span_cnt_o >= $past(span_cnt_o)));

endmodule

// File: rtl/cvp_init_ctrl.sv
module cvp_init_ctrl #(
    parameter int unsigned NUM_STAGES = 3,
    parameter int unsigned NUM_COLS   = 6,
    parameter logic [NUM_STAGES*NUM_COLS-1:0] RES_TABLE = 18'b010100_001010_100001,
    parameter int unsigned CNT_W      = 16,
    localparam int unsigned CV_W = NUM_COLS - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    output logic             grant_o,
    output logic [CV_W-1:0]  state_o,
    output logic [CV_W-1:0]  coll_vec_o,
    output logic [CNT_W-1:0] grant_cnt_o,
    output logic [CNT_W-1:0] span_cnt_o
);

    logic [CV_W-1:0] coll_vec;
    logic            grant;

    cvp_forbid_calc #(
        .NUM_STAGES (NUM_STAGES),
        .NUM_COLS   (NUM_COLS),
        .RES_TABLE  (RES_TABLE)
    ) u_forbid (
        .coll_vec_o (coll_vec)
    );

    cvp_state #(
        .CV_W (CV_W)
    ) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .coll_vec_i (coll_vec),
        .grant_o    (grant),
        .state_o    (state_o)
    );

    cvp_perf_cnt #(
        .CNT_W (CNT_W)
    ) u_perf (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_i     (grant),
        .grant_cnt_o (grant_cnt_o),
        .span_cnt_o  (span_cnt_o)
    );

    assign grant_o    = grant;
    assign coll_vec_o = coll_vec;

endmodule

// File: tb/sim_cvp_init_ctrl.sv
`timescale 1ns/1ps
module sim_cvp_init_ctrl;

    localparam int unsigned NS = 3;
    localparam int unsigned NC = 6;
    localparam logic [NS*NC-1:0] TB_TABLE = 18'b010100_001010_100001;
    localparam int unsigned DS = 4;
    localparam logic [DS*DS-1:0] DIAG_TABLE = 16'b1000_0100_0010_0001;
    localparam int unsigned CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;

    logic          grant0, grant1;
    logic [NC-2:0] state0, cv0;
    logic [DS-2:0] state1, cv1;
    logic [CW-1:0] gcnt0, span0, gcnt1, span1;

    always #4 clk = ~clk;

    cvp_init_ctrl #(.NUM_STAGES(NS), .NUM_COLS(NC), .RES_TABLE(TB_TABLE), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .grant_o(grant0), .state_o(state0),
        .coll_vec_o(cv0), .grant_cnt_o(gcnt0), .span_cnt_o(span0));

    cvp_init_ctrl #(.NUM_STAGES(DS), .NUM_COLS(DS), .RES_TABLE(DIAG_TABLE), .CNT_W(CW)) u1 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .grant_o(grant1), .state_o(state1),
        .coll_vec_o(cv1), .grant_cnt_o(gcnt1), .span_cnt_o(span1));

    int n_chk = 0;
    int n_bad = 0;
    int cyc = -1;
    int n_grant = 0;
    int n_req = 0;
    int first_g = -1;
    int last_g = -1;
    bit done = 1'b0;

    logic [NC-1:0] occ_m [NS];
    logic [NC-1:0] occ_s [NS];
    logic [1:0]    exp_q [$];
    logic [NC-2:0] cv_m;

    function automatic logic [NC-1:0] row(input int s);
        return TB_TABLE[s*NC +: NC];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: one call per cycle, pushes the expected grants of both instances.
    task automatic step(input logic r);
        logic hit;
        @(posedge clk);
        #1;
        req = r;
        cyc++;
        hit = 1'b0;
        for (int s = 0; s < NS; s++) begin
            if ((occ_m[s] & row(s)) != '0) hit = 1'b1;
        end
        exp_q.push_back({r && !hit, r});
        if (r) n_req++;
        if (r && !hit) begin
            for (int s = 0; s < NS; s++) occ_m[s] = occ_m[s] | row(s);
            n_grant++;
            if (first_g < 0) first_g = cyc;
            last_g = cyc;
        end
        for (int s = 0; s < NS; s++) occ_m[s] = occ_m[s] >> 1;
    endtask

    // Monitor: compares grants and keeps the stage occupancy scoreboard.
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            logic [1:0] e;
            e = exp_q.pop_front();
            chk("R3 R5 grant u0", 32'(grant0), 32'(e[1]));
            chk("R6 grant u1", 32'(grant1), 32'(e[0]));
            if (grant0) begin
                logic clash;
                clash = 1'b0;
                for (int s = 0; s < NS; s++) begin
                    if ((occ_s[s] & row(s)) != '0) clash = 1'b1;
                    occ_s[s] = occ_s[s] | row(s);
                end
                chk("R9 stage claimed twice", 32'(clash), 32'd0);
            end
            for (int s = 0; s < NS; s++) occ_s[s] = occ_s[s] >> 1;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int s = 0; s < NS; s++) begin
            occ_m[s] = '0;
            occ_s[s] = '0;
        end
        cv_m = '0;
        for (int lat = 1; lat < NC; lat++)
            for (int s = 0; s < NS; s++)
                for (int c = 0; c + lat < NC; c++)
                    if (row(s)[c] && row(s)[c+lat]) cv_m[lat-1] = 1'b1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R2 reset state", 32'(state0), 32'd0);
        chk("R2 reset grant count", 32'(gcnt0), 32'd0);
        chk("R2 reset span", 32'(span0), 32'd0);
        chk("R1 collision vector", 32'(cv0), 32'(cv_m));
        chk("R1 expected literal", 32'(cv0), 32'h12);
        chk("R6 diagonal vector", 32'(cv1), 32'd0);

        // Single initiation, then watch the state drain.
        step(1'b1);
        #1;
        chk("R2 first request granted", 32'(grant0), 32'd1);
        for (int k = 1; k <= NC; k++) begin
            step(1'b0);
            chk("R4 state after idle", 32'(state0), 32'(cv_m >> (k - 1)));
        end

        // Dense stream: greedy latencies 1,3,3 repeat.
        for (int i = 0; i < 40; i++) step(1'b1);

        // Pseudo-random stream.
        lfsr = 16'hACE1;
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[3]);
        end
        step(1'b0);

        @(posedge clk);
        #1;
        chk("R7 grant count", 32'(gcnt0), 32'(n_grant));
        chk("R8 span", 32'(span0), 32'(last_g - first_g));
        chk("R6 diagonal grant count", 32'(gcnt1), 32'(n_req));
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R3 actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule